// File: doc/BRIEF.md
# Precision-Switchable All-Pole Recursive Filter

This block is a fourth-order recursive filter. Each new output is the current input sample times a single feedforward gain, plus four weighted copies of its own most recent outputs. Past inputs are never weighted. A single multiply-accumulate datapath is shared by all five terms and steps through them one per clock. Its accumulator adder uses carry-lookahead blocks so that the carry path stays short across the wide sum.

A run-time switch sets the arithmetic width to either a narrow (8-bit) or a wide (16-bit) two's complement format. The five coefficients are signed fixed-point values with one integer bit, Q1.(W-1), written through a small address/data/write-enable port. Samples enter with a valid/ready handshake. Each result appears with a one-cycle valid pulse and is pushed into the output history.

Top module: `recur_iir`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0, `in_ready` is 1 and `out_sample` is 0. Reset also empties the output history, so the first result after reset depends on the feedforward term only.
- R2: Coefficient address 0 holds the feedforward gain b. With every feedback coefficient zero, the result is b·x(n) scaled back and saturated as described in R5 and R6.
- R3: Coefficient address k (k = 1..4) holds a_k, which weights y(n−k), the output produced k samples earlier. The result is b·x(n) + Σ a_k·y(n−k) using the full, unrounded sum.
- R4: `out_valid` pulses for exactly one cycle, five clock edges after the edge that accepts a sample (`in_valid` and `in_ready` both high). `in_ready` is low from the cycle after acceptance until the result appears.
- R5: The sum is divided by 2^(W−1) with round-half-up (add 2^(W−2), then arithmetic shift right). W is 16 when `wide_mode` = 1 and 8 when `wide_mode` = 0.
- R6: The rounded value is clamped to the signed W-bit range before it is output and before it enters the history.
- R7: With `wide_mode` = 0, only bits [7:0] of the input sample and of each coefficient are used, each sign-extended. `out_sample[15:7]` are then all copies of the sign.
- R8: A change of `wide_mode` clears the whole history on the next clock edge. A sample in progress at that edge is cancelled and produces no `out_valid`.
- R9: Reset leaves the coefficient store unchanged. After reset, samples are filtered with the last written coefficients.
- R10: `in_valid` while `in_ready` is low is ignored. It produces no extra result and does not alter the sample being processed or the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 16-bit arithmetic, 0 selects 8-bit |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index: 0 = b, 1..4 = a1..a4 |
| coef_data | input | 16 | Coefficient value, Q1.(W−1) |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter idle and able to accept |
| in_sample | input | 16 | Input sample x(n), two's complement |
| out_valid | output | 1 | One-cycle pulse when y(n) is on `out_sample` |
| out_sample | output | 16 | Result y(n), sign-extended in narrow mode |

## Verification
The properties assume that `rst` is held high from time zero and that no sample is accepted in the same cycle as a mode change. Under those conditions, a result pulse can never follow another directly, and a cancelled sample can never leave a result. The stimulus changes `wide_mode` only while the filter is idle, or deliberately while a sample is in flight to exercise cancellation. It drives coefficient writes only between samples. It pulses `in_valid` during busy cycles only after the sample has been accepted, so the scoreboard's one-to-one match between accepted samples and results stays exact.

// File: rtl/iir_pkg.sv
package iir_pkg;
  typedef enum logic [0:0] {
    PREC_NARROW = 1'b0,
    PREC_WIDE   = 1'b1
  } prec_e;
endpackage

// File: rtl/iir_cla_adder.sv
// Two-level carry-lookahead adder: 4-bit lookahead groups with group
// generate/propagate feeding the inter-group carry.
module iir_cla_adder #(
  parameter int N = 36
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);
  localparam int NB = (N + 3) / 4;
  localparam int NP = NB * 4;

  logic [NP-1:0] ap, bp, g, p, cb, sfull;
  logic [NB-1:0] cgrp;

  assign ap = NP'(a);
  assign bp = NP'(b);
  assign g  = ap & bp;
  assign p  = ap ^ bp;
  assign cgrp[0] = 1'b0;

  for (genvar j = 0; j < NB; j++) begin : g_grp
    localparam int B = 4 * j;
    assign cb[B]   = cgrp[j];
    assign cb[B+1] = g[B] | (p[B] & cgrp[j]);
    assign cb[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & cgrp[j]);
    assign cb[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                   | (p[B+2] & p[B+1] & p[B] & cgrp[j]);
    if (j < NB - 1) begin : g_next
      logic grp_g, grp_p;
      assign grp_g = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                   | (p[B+3] & p[B+2] & p[B+1] & g[B]);
      assign grp_p = &p[B +: 4];
      assign cgrp[j+1] = grp_g | (grp_p & cgrp[j]);
    end
  end

  assign sfull = p ^ cb;
  assign sum   = sfull[N-1:0];
endmodule

// File: rtl/iir_mac.sv
// One multiply-accumulate step: acc_out = acc_in + coef * opnd.
module iir_mac #(
  parameter int DW   = 16,
  parameter int ACCW = 2 * DW + 4
) (
  input  logic signed [DW-1:0]   coef,
  input  logic signed [DW-1:0]   opnd,
  input  logic signed [ACCW-1:0] acc_in,
  output logic signed [ACCW-1:0] acc_out
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0]   prod;
  logic        [ACCW-1:0] prod_ext;
  logic        [ACCW-1:0] sum_u;

  assign prod     = coef * opnd;
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

  iir_cla_adder #(.N(ACCW)) u_add (
    .a   (acc_in),
    .b   (prod_ext),
    .sum (sum_u)
  );

  assign acc_out = signed'(sum_u);
endmodule

// File: rtl/iir_round_sat.sv
// Scales the accumulator back by W-1 bits (round half up) and clamps to W bits.
module iir_round_sat #(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int ACCW = 2 * DW + 4
) (
  input  logic signed [ACCW-1:0] acc,
  input  logic                   wide,
  output logic        [DW-1:0]   y
);
  localparam logic signed [ACCW-1:0] ONE   = ACCW'(1);
  localparam logic signed [ACCW-1:0] MAX_W = (ONE <<< (DW-1)) - ONE;
  localparam logic signed [ACCW-1:0] MIN_W = ~MAX_W;
  localparam logic signed [ACCW-1:0] MAX_N = (ONE <<< (NW-1)) - ONE;
  localparam logic signed [ACCW-1:0] MIN_N = ~MAX_N;

  logic signed [ACCW-1:0] sum_w, sum_n, q_w, q_n, q, hi, lo, clamped;

  assign sum_w = acc + (ONE <<< (DW-2));
  assign sum_n = acc + (ONE <<< (NW-2));
  assign q_w   = sum_w >>> (DW-1);
  assign q_n   = sum_n >>> (NW-1);

  always_comb begin
    q  = wide ? q_w   : q_n;
    hi = wide ? MAX_W : MAX_N;
    lo = wide ? MIN_W : MIN_N;
    if (q > hi)      clamped = hi;
    else if (q < lo) clamped = lo;
    else             clamped = q;
  end

  assign y = clamped[DW-1:0];
endmodule

// File: rtl/iir_coef_bank.sv
// Small coefficient store; not reset so it keeps values across reset.
module iir_coef_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 5,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/iir_history.sv
// Shift register of past outputs; stage 0 is y(n-1).
module iir_history #(
  parameter int DW   = 16,
  parameter int TAPS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               push,
  input  logic [DW-1:0]      din,
  output logic [TAPS*DW-1:0] dout
);
  logic [DW-1:0] stage [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        stage[k] <= '0;
      end else if (push) begin
        if (k == 0) stage[k] <= din;
        else        stage[k] <= stage[(k > 0) ? k-1 : 0];
      end
    end
    assign dout[k*DW +: DW] = stage[k];
  end
endmodule

// File: rtl/recur_iir.sv
module recur_iir
  import iir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int TAPS = 4,
  parameter int CAW  = $clog2(TAPS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wide_mode,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [DW-1:0]  coef_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_sample,
  output logic           out_valid,
  output logic [DW-1:0]  out_sample
);
  localparam int ACCW = 2 * DW + 4;
  localparam logic [CAW-1:0] LAST = CAW'(TAPS);

  prec_e                  mode_r;
  logic                   busy;
  logic [CAW-1:0]         step;
  logic [DW-1:0]          x_hold;
  logic signed [ACCW-1:0] acc, acc_next;
  logic [DW-1:0]          coef_rd, coef_op, opnd, y_sat;
  logic [TAPS*DW-1:0]     hist_flat;
  logic [DW-1:0]          opnd_tab [TAPS+1];
  logic                   wide_r, mode_chg, accept, last_step, push;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic w);
    return w ? v : {{(DW-NW){v[NW-1]}}, v[NW-1:0]};
  endfunction

  assign wide_r    = (mode_r == PREC_WIDE);
  assign mode_chg  = (prec_e'(wide_mode) != mode_r);
  assign in_ready  = !busy;
  assign accept    = in_valid && !busy;
  assign last_step = (step == LAST);
  assign push      = busy && last_step && !mode_chg;

  iir_coef_bank #(.DW(DW), .DEPTH(TAPS+1), .AW(CAW)) u_coef (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_data),
    .raddr (step),
    .rdata (coef_rd)
  );

  iir_history #(.DW(DW), .TAPS(TAPS)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .clr  (mode_chg),
    .push (push),
    .din  (y_sat),
    .dout (hist_flat)
  );

  assign opnd_tab[0] = x_hold;
  for (genvar k = 1; k <= TAPS; k++) begin : g_opnd
    assign opnd_tab[k] = hist_flat[(k-1)*DW +: DW];
  end

  assign coef_op = fit(coef_rd, wide_r);
  assign opnd    = opnd_tab[step];

  iir_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
    .coef    (signed'(coef_op)),
    .opnd    (signed'(opnd)),
    .acc_in  (acc),
    .acc_out (acc_next)
  );

  iir_round_sat #(.DW(DW), .NW(NW), .ACCW(ACCW)) u_rs (
    .acc  (acc_next),
    .wide (wide_r),
    .y    (y_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r     <= prec_e'(wide_mode);
      busy       <= 1'b0;
      step       <= '0;
      acc        <= '0;
      x_hold     <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      mode_r    <= prec_e'(wide_mode);
      if (busy && mode_chg) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (last_step) begin
          busy       <= 1'b0;
          out_valid  <= 1'b1;
          out_sample <= y_sat;
        end else begin
          acc  <= acc_next;
          step <= step + 1'b1;
        end
      end
      if (accept) begin
        busy   <= 1'b1;
        step   <= '0;
        acc    <= '0;
        x_hold <= fit(in_sample, wide_mode);
      end
    end
  end
endmodule

// File: rtl/iir_checker.sv
module iir_checker #(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int TAPS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wide_mode,
  input logic               mode_r,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic [DW-1:0]      out_sample,
  input logic [TAPS*DW-1:0] hist_flat,
  input logic [DW-1:0]      x_hold
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R4
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (wide_mode == mode_r)) |=> !in_ready);

  // R7
  a_r7_narrow_sign: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_r) |->
      ((&out_sample[DW-1:NW-1]) || !(|out_sample[DW-1:NW-1])));

  // R8
  a_r8_switch_clears: assert property (@(posedge clk) disable iff (rst)
    (wide_mode != mode_r) |=> ((hist_flat == '0) && !out_valid));

  // R10
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(x_hold));
endmodule

bind recur_iir iir_checker #(.DW(DW), .NW(NW), .TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wide_mode  (wide_mode),
  .mode_r     (mode_r),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .hist_flat  (hist_flat),
  .x_hold     (x_hold)
);

// File: tb/sim_recur_iir.sv
`timescale 1ns/1ps
module sim_recur_iir;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b1;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic [15:0] out_sample;

  always #2.5 clk = ~clk;

  recur_iir u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .out_valid(out_valid),
    .out_sample(out_sample)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int bad = 0;
  int pulses = 0;
  string cur_tag = "R4";

  logic [15:0] exp_q[$];
  int          when_q[$];
  string       tag_q[$];

  logic [15:0] cf [5];
  longint      hm [4];
  bit          mm = 1'b1;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint sx(logic [15:0] v, bit w);
    if (w) return longint'(signed'(v));
    return longint'(signed'(v[7:0]));
  endfunction

  function automatic logic [15:0] model(logic [15:0] x);
    longint acc, r, hi, lo;
    int sh;
    acc = sx(cf[0], mm) * sx(x, mm);
    for (int k = 0; k < 4; k++) acc += sx(cf[k+1], mm) * hm[k];
    sh = mm ? 15 : 7;
    r  = (acc + (64'sd1 <<< (sh - 1))) >>> sh;
    hi = mm ? 32767 : 127;
    lo = mm ? -32768 : -128;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    for (int k = 3; k > 0; k--) hm[k] = hm[k-1];
    hm[0] = r;
    return r[15:0];
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 4; k++) hm[k] = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = a; coef_data = d;
    @(negedge clk);
    coef_we = 1'b0;
    cf[a] = d;
  endtask

  task automatic send(logic [15:0] x, string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sample = x;
    exp_q.push_back(model(x));
    when_q.push_back(cyc + 6);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R4", in_ready, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare every result against the scoreboard.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      pulses++;
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, out_sample, -1);
      end else begin
        logic [15:0] e;
        int w;
        string t;
        e = exp_q.pop_front(); w = when_q.pop_front(); t = tag_q.pop_front();
        chk(out_sample == e, t, signed'(out_sample), signed'(e));
        chk(cyc == w, "R4", cyc, w);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int p0;
    clear_model();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_sample == 16'h0, "R1", out_sample, 0);
    rst = 1'b0;

    // R2 / R5: feedforward only, gain 0.5
    wr(0, 16'h4000);
    for (int k = 1; k < 5; k++) wr(3'(k), 16'h0000);
    send(16'd1000, "R2");
    send(-16'sd3, "R2");
    send(16'd12345, "R2");
    send(16'd1, "R5");      // 0.5 rounds up to 1
    send(16'hFFFF, "R5");   // -0.5 rounds up to 0
    drain();

    // R3: full recursion, impulse response then extra samples
    wr(0, 16'h2000); wr(1, 16'h4000); wr(2, 16'hE000);
    wr(3, 16'h1000); wr(4, 16'h0800);
    send(16'd20000, "R3");
    for (int k = 0; k < 6; k++) send(16'd0, "R3");
    send(16'd5000, "R3");
    send(-16'sd7000, "R3");
    drain();

    // R6: wide saturation, both ends
    wr(0, 16'h7FFF); wr(1, 16'h7FFF);
    wr(2, 16'h0); wr(3, 16'h0); wr(4, 16'h0);
    for (int k = 0; k < 3; k++) send(16'd32767, "R6");
    wr(0, 16'h8000); wr(1, 16'h0000);
    send(16'h8000, "R6");   // -1 * -1 clamps to max
    wr(1, 16'h7FFF);
    for (int k = 0; k < 3; k++) send(16'd32767, "R6");
    drain();

    // R10: in_valid during busy is ignored
    wr(0, 16'h4000); wr(1, 16'h2000);
    cur_tag = "R10";
    p0 = pulses;
    send(16'd3000, "R10");
    in_valid = 1'b1; in_sample = 16'h7777;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk(pulses == p0 + 1, "R10", pulses - p0, 1);
    send(16'd100, "R10");
    drain();

    // R7: narrow mode, upper bits of operands are junk
    @(negedge clk);
    wide_mode = 1'b0; mm = 1'b0; clear_model();
    repeat (2) @(negedge clk);
    wr(0, 16'hAB40); wr(1, 16'h1230); wr(2, 16'hFFE0);
    wr(3, 16'h5500); wr(4, 16'hCC10);
    send(16'h5A64, "R7");
    send(16'h0080, "R7");
    send(16'h337F, "R7");
    send(16'hFF9C, "R7");
    drain();
    wr(0, 16'h007F); wr(1, 16'h007F);
    for (int k = 0; k < 3; k++) send(16'h007F, "R6");
    wr(0, 16'h0080); wr(1, 16'h0000);
    send(16'h0080, "R6");
    drain();

    // R8: switch mode while a sample is in flight
    cur_tag = "R8";
    p0 = pulses;
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'h0010;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    wide_mode = 1'b1; mm = 1'b1; clear_model();
    repeat (10) @(negedge clk);
    chk(pulses == p0, "R8", pulses - p0, 0);
    wr(0, 16'h4000); wr(1, 16'h7000);
    send(16'd2000, "R8");
    send(16'd0, "R8");
    drain();

    // R9: reset keeps coefficients, empties history
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst = 1'b0; clear_model();
    send(16'd8000, "R9");
    send(16'd0, "R9");
    drain();

    finish_run();
  end
endmodule